// File: doc/BRIEF.md
# Match-Interrupt Real-Time Clock Counter

This block keeps a 32-bit running count of the rising edges of a slow 32.768 kHz clock input, sampled in the fast system clock domain. A two-stage synchroniser and an edge detector turn the slow input into single-cycle advance strobes. Each strobe adds one to the count. The count wraps from all-ones to zero.

Software sets the count's start value through a load register. The load takes effect at once, even while the counter is running. A match register holds a compare value. When the count steps onto that value, a sticky status flag is set and the counter keeps running. If the mask bit is set, the flag also drives the interrupt output. A clear write drops the flag.

A run bit gates counting, and a mode field must select RTC operation. A stall bit lets an external debug-halt input freeze counting. The mode and match registers are locked while the run bit is set.

Top module: `rtc_tick_counter`

## Requirements
- R1: After the asynchronous active-low reset, the count, the status flag, `irq_o` and all control fields read as zero.
- R2: The count advances by exactly one for each rising edge of `tick_i`, and only while all three of these hold: run (address 0, bit 0) is 1, the mode field (address 1, bits 2:0) equals 1, and no stall applies. The new count is visible by the third rising clock edge after `tick_i` rises.
- R3: When an advance makes the count equal the match register (address 2), the status flag is set. The flag reads at address 5 or 7, bit 0. Counting then continues past the match value.
- R4: The match is checked only on an advance. Loading a value equal to the match register does not set the status flag.
- R5: `irq_o` is high exactly when the status flag is set and the mask bit (address 4, bit 0) is 1. Reads at addresses 5 and 7 return the interrupt state in bit 1.
- R6: A write to address 5 with bit 0 set clears the status flag. A write there with bit 0 clear has no effect. If a clear and a new match fall in the same cycle, the match wins.
- R7: A write to address 3 sets the count to the written value on the next clock edge, whether the counter is running or not. A load takes priority over an advance in the same cycle. Reads at addresses 3 and 6 return the live count.
- R8: An advance from 0xFFFFFFFF gives 0.
- R9: Writes to the mode and match registers are ignored while run is 1.
- R10: With the stall bit (address 0, bit 1) set, rising edges of `tick_i` are ignored while `halt_i` is high. With the stall bit clear, `halt_i` has no effect.
- R11: With run cleared, the count holds its value across `tick_i` edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | 32.768 kHz clock input, asynchronous to clk_i |
| halt_i | input | 1 | Debug-halt request |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i, combinational |
| irq_o | output | 1 | Masked match interrupt |

## Verification
Register writes take effect on the clock edge that captures them, so the bench drives writes on the falling edge and reads back on a later falling edge. A count advance reaches the read port on the third rising edge after `tick_i` rises. The bench therefore holds each tick level for four cycles before the next change and samples only after the low phase has passed. The status flag and `irq_o` follow the same edge as the advance that matches, and the bench reads them at the same point as the count.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int unsigned ADDR_W = 3;
  localparam int unsigned MODE_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL   = 3'd0,
    A_MODE   = 3'd1,
    A_MATCH  = 3'd2,
    A_LOAD   = 3'd3,
    A_MASK   = 3'd4,
    A_CLEAR  = 3'd5,
    A_COUNT  = 3'd6,
    A_STATUS = 3'd7
  } reg_addr_e;

  localparam logic [MODE_W-1:0] MODE_RTC = 3'd1;
endpackage

// File: rtl/rtc_tick_sync.sv
module rtc_tick_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= tick_i;
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= {sync_q[STAGES-2:0], tick_i};
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) last_q <= 1'b0;
    else         last_q <= sync_q[STAGES-1];

  assign rise_o = sync_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/rtc_regs.sv
module rtc_regs
  import rtc_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              run_o,
  output logic              stall_o,
  output logic [MODE_W-1:0] mode_o,
  output logic [DATA_W-1:0] match_o,
  output logic              mask_o,
  output logic              load_o,
  output logic              clear_o
);
  logic              run_q, stall_q, mask_q;
  logic [MODE_W-1:0] mode_q;
  logic [DATA_W-1:0] match_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q   <= 1'b0;
      stall_q <= 1'b0;
      mask_q  <= 1'b0;
      mode_q  <= '0;
      match_q <= '0;
    end else if (we_i) begin
      case (addr_i)
        A_CTRL: begin
          run_q   <= wdata_i[0];
          stall_q <= wdata_i[1];
        end
        A_MODE:  if (!run_q) mode_q  <= wdata_i[MODE_W-1:0];
        A_MATCH: if (!run_q) match_q <= wdata_i;
        A_MASK:  mask_q <= wdata_i[0];
        default: ;
      endcase
    end
  end

  assign run_o   = run_q;
  assign stall_o = stall_q;
  assign mode_o  = mode_q;
  assign match_o = match_q;
  assign mask_o  = mask_q;
  assign load_o  = we_i && (addr_i == A_LOAD);
  assign clear_o = we_i && (addr_i == A_CLEAR) && wdata_i[0];
endmodule

// File: rtl/rtc_count_core.sv
module rtc_count_core #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rise_i,
  input  logic             active_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic [CNT_W-1:0] match_i,
  input  logic             clear_i,
  output logic [CNT_W-1:0] count_o,
  output logic             status_o,
  output logic             inc_o
);
  logic [CNT_W-1:0] count_q, count_nxt;
  logic             status_q, inc;

  assign inc       = rise_i & active_i & ~load_i;
  assign count_nxt = count_q + CNT_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)     count_q <= '0;
    else if (load_i) count_q <= load_val_i;
    else if (inc)    count_q <= count_nxt;

  // set has priority over clear
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)                           status_q <= 1'b0;
    else if (inc && count_nxt == match_i)  status_q <= 1'b1;
    else if (clear_i)                      status_q <= 1'b0;

  assign count_o  = count_q;
  assign status_o = status_q;
  assign inc_o    = inc;
endmodule

// File: rtl/rtc_tick_counter.sv
module rtc_tick_counter
  import rtc_pkg::*;
#(
  parameter int unsigned CNT_W       = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             halt_i,
  input  logic             reg_we_i,
  input  logic [2:0]       reg_addr_i,
  input  logic [CNT_W-1:0] reg_wdata_i,
  output logic [CNT_W-1:0] reg_rdata_o,
  output logic             irq_o
);
  logic              rise, run, stall, mask, load, clear, active, inc, sts;
  logic [MODE_W-1:0] mode;
  logic [CNT_W-1:0]  match_val, cnt;

  rtc_tick_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_i(tick_i),
    .rise_o(rise)
  );

  rtc_regs #(.DATA_W(CNT_W)) u_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (reg_we_i),
    .addr_i (reg_addr_i),
    .wdata_i(reg_wdata_i),
    .run_o  (run),
    .stall_o(stall),
    .mode_o (mode),
    .match_o(match_val),
    .mask_o (mask),
    .load_o (load),
    .clear_o(clear)
  );

  assign active = run && (mode == MODE_RTC) && !(stall && halt_i);

  rtc_count_core #(.CNT_W(CNT_W)) u_core (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rise_i    (rise),
    .active_i  (active),
    .load_i    (load),
    .load_val_i(reg_wdata_i),
    .match_i   (match_val),
    .clear_i   (clear),
    .count_o   (cnt),
    .status_o  (sts),
    .inc_o     (inc)
  );

  assign irq_o = sts & mask;

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      A_CTRL:            reg_rdata_o[1:0]        = {stall, run};
      A_MODE:            reg_rdata_o[MODE_W-1:0] = mode;
      A_MATCH:           reg_rdata_o             = match_val;
      A_LOAD, A_COUNT:   reg_rdata_o             = cnt;
      A_MASK:            reg_rdata_o[0]          = mask;
      A_CLEAR, A_STATUS: reg_rdata_o[1:0]        = {irq_o, sts};
      default: ;
    endcase
  end
endmodule

// File: rtl/rtc_tick_counter_chk.sv
module rtc_tick_counter_chk #(
  parameter int unsigned CNT_W = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             halt_i,
  input logic             reg_we_i,
  input logic [2:0]       reg_addr_i,
  input logic [CNT_W-1:0] reg_wdata_i,
  input logic             irq_o,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] match_val,
  input logic             sts,
  input logic             run,
  input logic             stall,
  input logic             mask,
  input logic             inc
);
  logic load_wr;
  assign load_wr = reg_we_i && (reg_addr_i == 3'd3);

  a_r2_step_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_wr |=> (cnt == $past(cnt) || cnt == $past(cnt) + CNT_W'(1)));

  a_r3_match_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc && (cnt + CNT_W'(1)) == match_val) |=> sts);

  a_r5_irq_needs_status: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> sts);

  a_r5_irq_masked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mask |-> !irq_o);

  a_r6_drop_by_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sts) |-> $past(reg_we_i && reg_addr_i == 3'd5 && reg_wdata_i[0]));

  a_r7_load_value: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_wr |=> cnt == $past(reg_wdata_i));

  a_r9_match_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && reg_we_i && reg_addr_i == 3'd2) |=> $stable(match_val));

  a_r10_stall_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stall && halt_i && !load_wr) |=> $stable(cnt));

  a_r11_idle_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run && !load_wr) |=> $stable(cnt));
endmodule

bind rtc_tick_counter rtc_tick_counter_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .halt_i     (halt_i),
  .reg_we_i   (reg_we_i),
  .reg_addr_i (reg_addr_i),
  .reg_wdata_i(reg_wdata_i),
  .irq_o      (irq_o),
  .cnt        (cnt),
  .match_val  (match_val),
  .sts        (sts),
  .run        (run),
  .stall      (stall),
  .mask       (mask),
  .inc        (inc)
);

// File: tb/rtc_tick_counter_test.sv
module rtc_tick_counter_test;
  localparam logic [2:0] AD_CTRL = 3'd0, AD_MODE = 3'd1, AD_MATCH = 3'd2,
                         AD_LOAD = 3'd3, AD_MASK = 3'd4, AD_CLEAR = 3'd5,
                         AD_COUNT = 3'd6, AD_STATUS = 3'd7;

  typedef struct packed {
    logic [31:0] ld;
    logic [31:0] mt;
    logic [7:0]  ticks;
    logic [31:0] exp_cnt;
    logic        exp_sts;
  } vec_t;

  localparam int NVEC = 6;
  localparam vec_t VEC [NVEC] = '{
    '{32'd0,         32'd5,         8'd3, 32'd3,   1'b0},
    '{32'd0,         32'd5,         8'd5, 32'd5,   1'b1},
    '{32'd10,        32'd12,        8'd7, 32'd17,  1'b1},
    '{32'hFFFFFFFE,  32'd0,         8'd3, 32'd1,   1'b1},
    '{32'd100,       32'd50,        8'd4, 32'd104, 1'b0},
    '{32'hFFFFFFFF,  32'hFFFFFFFF,  8'd2, 32'd1,   1'b0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        halt = 1'b0;
  logic        we = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  rtc_tick_counter uut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .tick_i     (tick),
    .halt_i     (halt),
    .reg_we_i   (we),
    .reg_addr_i (addr),
    .reg_wdata_i(wdata),
    .reg_rdata_o(rdata),
    .irq_o      (irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #2 d = rdata;
  endtask

  task automatic pulse(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      repeat (4) @(negedge clk);
      tick = 1'b0;
      repeat (4) @(negedge clk);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(AD_COUNT, d);  chk("R1 count", d, 32'd0);
    rd(AD_STATUS, d); chk("R1 status", d, 32'd0);
    rd(AD_CTRL, d);   chk("R1 ctrl", d, 32'd0);
    chk("R1 irq", {31'd0, irq}, 32'd0);

    wr(AD_MASK, 32'd1);
    for (int v = 0; v < NVEC; v++) begin
      wr(AD_CTRL, 32'd0);
      wr(AD_MODE, 32'd1);
      wr(AD_MATCH, VEC[v].mt);
      wr(AD_LOAD, VEC[v].ld);
      wr(AD_CLEAR, 32'd1);
      wr(AD_CTRL, 32'd1);
      pulse(int'(VEC[v].ticks));
      rd(AD_COUNT, d);  chk("R2 R3 R8 count", d, VEC[v].exp_cnt);
      rd(AD_STATUS, d); chk("R3 R4 status", {31'd0, d[0]}, {31'd0, VEC[v].exp_sts});
      chk("R5 irq", {31'd0, irq}, {31'd0, VEC[v].exp_sts});
    end

    // status set from last vector? no: set one now
    wr(AD_CTRL, 32'd0);
    wr(AD_MATCH, 32'd2);
    wr(AD_LOAD, 32'd1);
    wr(AD_CTRL, 32'd1);
    pulse(1);
    rd(AD_STATUS, d); chk("R3 set", d, 32'd3);
    wr(AD_MASK, 32'd0);
    rd(AD_STATUS, d); chk("R5 masked status", d, 32'd1);
    chk("R5 masked irq", {31'd0, irq}, 32'd0);
    wr(AD_CLEAR, 32'd0);
    rd(AD_STATUS, d); chk("R6 clear bit0 zero ignored", d, 32'd1);
    wr(AD_CLEAR, 32'd1);
    rd(AD_STATUS, d); chk("R6 cleared", d, 32'd0);

    // R9 locked while running
    wr(AD_MATCH, 32'd77);
    rd(AD_MATCH, d); chk("R9 match locked", d, 32'd2);
    wr(AD_MODE, 32'd2);
    rd(AD_MODE, d);  chk("R9 mode locked", d, 32'd1);

    // R7 load while running
    wr(AD_LOAD, 32'd500);
    rd(AD_LOAD, d); chk("R7 load running", d, 32'd500);

    // R10 stall
    wr(AD_CTRL, 32'd3);
    halt = 1'b1;
    pulse(2);
    rd(AD_COUNT, d); chk("R10 stalled", d, 32'd500);
    halt = 1'b0;
    pulse(1);
    rd(AD_COUNT, d); chk("R10 unhalted", d, 32'd501);
    wr(AD_CTRL, 32'd1);
    halt = 1'b1;
    pulse(1);
    rd(AD_COUNT, d); chk("R10 stall off", d, 32'd502);
    halt = 1'b0;

    // R11 run cleared
    wr(AD_CTRL, 32'd0);
    pulse(2);
    rd(AD_COUNT, d); chk("R11 hold", d, 32'd502);

    // R2 wrong mode
    wr(AD_MODE, 32'd2);
    wr(AD_CTRL, 32'd1);
    pulse(2);
    rd(AD_COUNT, d); chk("R2 mode not rtc", d, 32'd502);

    done = 1;
    summary();
  end
endmodule